// File: doc/BRIEF.md
# Address-Match Busy Arbiter

This block sits beside a two-port shared memory array and watches the enable and address of each port. When both ports are enabled and point at the same word, it decides which port keeps access. It raises a registered busy flag toward the other port and strips that port's write strobe before it reaches the array. The winner is the port that was already sitting on the address when the other arrived. If both arrive in the same cycle, the left port wins. The winner keeps priority until the addresses part or either port is deselected.

A mode strap sets the block's role. As master it arbitrates and drives the busy flags. As slave it drives no busy of its own: each port's write is inhibited by a busy input that an external master supplies. The writes the block passes on are the array's actual write strobes. Reads are never held back.

Top module: `busy_arbiter`

## Requirements
- R1: In master mode (`isMaster`=1), a busy output goes high only in the cycle after a cycle in which both ports were enabled with equal addresses. It never goes high otherwise.
- R2: At no time are `busyOutL` and `busyOutR` both high.
- R3: On a new collision, a port that was enabled on the same address in the previous cycle wins over a port that just arrived. If both or neither were there before, the left port wins. The loser's busy rises in the next cycle.
- R4: While the collision continues without a break, the winner does not change.
- R5: Busy falls in the cycle after the addresses differ or either port is deselected.
- R6: In master mode, in every cycle of a collision, the losing port's write strobe output is low in that same cycle, including the first cycle.
- R7: The winning port's write, and any write outside a collision, passes to `wrGateL`/`wrGateR` in the same cycle.
- R8: In slave mode (`isMaster`=0), both busy outputs are low, and `busyInL`/`busyInR` high blocks that port's write in the same cycle. Address collisions have no effect in this mode.
- R9: In master mode, `busyInL` and `busyInR` have no effect on any output.
- R10: A write strobe never passes for a port whose enable is low.
- R11: After reset both busy outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| isMaster | input | 1 | 1 = arbitrate and drive busy, 0 = take busy from inputs |
| enL | input | 1 | Left port enable |
| addrL | input | ADDR_W | Left port word address |
| wrL | input | 1 | Left port write request |
| enR | input | 1 | Right port enable |
| addrR | input | ADDR_W | Right port word address |
| wrR | input | 1 | Right port write request |
| busyInL | input | 1 | External busy for left port (slave mode) |
| busyInR | input | 1 | External busy for right port (slave mode) |
| busyOutL | output | 1 | Left port lost arbitration (registered) |
| busyOutR | output | 1 | Right port lost arbitration (registered) |
| wrGateL | output | 1 | Write strobe to the array, left port |
| wrGateR | output | 1 | Write strobe to the array, right port |

## Verification
The write gates are combinational. The bench checks them 1 ns after it changes the inputs, in the same cycle as the stimulus. Both busy flags rise or fall one clock edge after the collision starts or ends, so they are compared in the cycle after the stimulus. A behavioural model keeps the owner, the previous enables and addresses, and the busy state. It updates them at each rising edge and predicts every output for the next cycle. Directed scenarios cover arrival order, ties, holding, release by address and by enable, and both modes. A random phase on a four-word address range then runs many collisions back to back.

// File: rtl/busy_arbiter_pkg.sv
package busy_arbiter_pkg;
  typedef enum logic [1:0] {
    OWN_NONE  = 2'd0,
    OWN_LEFT  = 2'd1,
    OWN_RIGHT = 2'd2
  } owner_e;

  // control -> datapath: which side's write must be removed this cycle
  typedef struct packed {
    logic maskL;
    logic maskR;
  } gateStrobe_t;
endpackage

// File: rtl/busy_arbiter_datapath.sv
module busy_arbiter_datapath
  import busy_arbiter_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              isMaster,
  input  logic              enL,
  input  logic [ADDR_W-1:0] addrL,
  input  logic              wrL,
  input  logic              enR,
  input  logic [ADDR_W-1:0] addrR,
  input  logic              wrR,
  input  logic              busyInL,
  input  logic              busyInR,
  input  gateStrobe_t       strobe,
  output logic              collide,
  output logic              leftHeld,
  output logic              rightHeld,
  output logic              wrGateL,
  output logic              wrGateR
);
  localparam int NPORT = 2;

  logic [ADDR_W-1:0] curAddr [NPORT];
  logic [NPORT-1:0]  curEn;
  logic [NPORT-1:0]  held;

  assign curAddr[0] = addrL;
  assign curAddr[1] = addrR;
  assign curEn      = {enR, enL};

  // each port remembers where it was last cycle to decide arrival order
  for (genvar p = 0; p < NPORT; p++) begin : g_port
    logic [ADDR_W-1:0] prevAddr;
    logic              prevEn;
    always_ff @(posedge clk) begin
      if (!rstN) begin
        prevAddr <= '0;
        prevEn   <= 1'b0;
      end else begin
        prevAddr <= curAddr[p];
        prevEn   <= curEn[p];
      end
    end
    assign held[p] = prevEn && (prevAddr == curAddr[p]);
  end

  assign collide   = enL && enR && (addrL == addrR);
  assign leftHeld  = held[0];
  assign rightHeld = held[1];

  always_comb begin
    if (isMaster) begin
      wrGateL = wrL && enL && !strobe.maskL;
      wrGateR = wrR && enR && !strobe.maskR;
    end else begin
      wrGateL = wrL && enL && !busyInL;
      wrGateR = wrR && enR && !busyInR;
    end
  end
endmodule

// File: rtl/busy_arbiter_control.sv
module busy_arbiter_control
  import busy_arbiter_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        isMaster,
  input  logic        collide,
  input  logic        leftHeld,
  input  logic        rightHeld,
  output gateStrobe_t strobe,
  output logic        busyOutL,
  output logic        busyOutR
);
  owner_e owner, ownerNext;
  logic   winLeft;
  logic   active;
  logic   busyLReg, busyRReg;

  assign active = isMaster && collide;

  always_comb begin
    unique case (owner)
      OWN_LEFT:  winLeft = 1'b1;
      OWN_RIGHT: winLeft = 1'b0;
      default:   winLeft = leftHeld || !rightHeld;
    endcase
  end

  always_comb begin
    strobe.maskL = active && !winLeft;
    strobe.maskR = active && winLeft;
    ownerNext    = !active ? OWN_NONE : (winLeft ? OWN_LEFT : OWN_RIGHT);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      owner    <= OWN_NONE;
      busyLReg <= 1'b0;
      busyRReg <= 1'b0;
    end else begin
      owner    <= ownerNext;
      busyLReg <= strobe.maskL;
      busyRReg <= strobe.maskR;
    end
  end

  assign busyOutL = busyLReg && isMaster;
  assign busyOutR = busyRReg && isMaster;
endmodule

// File: rtl/busy_arbiter.sv
module busy_arbiter
  import busy_arbiter_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              isMaster,
  input  logic              enL,
  input  logic [ADDR_W-1:0] addrL,
  input  logic              wrL,
  input  logic              enR,
  input  logic [ADDR_W-1:0] addrR,
  input  logic              wrR,
  input  logic              busyInL,
  input  logic              busyInR,
  output logic              busyOutL,
  output logic              busyOutR,
  output logic              wrGateL,
  output logic              wrGateR
);
  gateStrobe_t strobe;
  logic collide, leftHeld, rightHeld;

  busy_arbiter_datapath #(.ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rstN(rstN), .isMaster(isMaster),
    .enL(enL), .addrL(addrL), .wrL(wrL),
    .enR(enR), .addrR(addrR), .wrR(wrR),
    .busyInL(busyInL), .busyInR(busyInR),
    .strobe(strobe), .collide(collide),
    .leftHeld(leftHeld), .rightHeld(rightHeld),
    .wrGateL(wrGateL), .wrGateR(wrGateR)
  );

  busy_arbiter_control u_ctl (
    .clk(clk), .rstN(rstN), .isMaster(isMaster),
    .collide(collide), .leftHeld(leftHeld), .rightHeld(rightHeld),
    .strobe(strobe), .busyOutL(busyOutL), .busyOutR(busyOutR)
  );
endmodule

// File: rtl/busy_arbiter_checker.sv
module busy_arbiter_checker #(
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rstN,
  input logic              isMaster,
  input logic              enL,
  input logic [ADDR_W-1:0] addrL,
  input logic              wrL,
  input logic              enR,
  input logic [ADDR_W-1:0] addrR,
  input logic              wrR,
  input logic              busyInL,
  input logic              busyInR,
  input logic              busyOutL,
  input logic              busyOutR,
  input logic              wrGateL,
  input logic              wrGateR
);
  logic hit;
  assign hit = enL && enR && (addrL == addrR);

  p_one_side_r2: assert property (@(posedge clk) disable iff (!rstN)
    !(busyOutL && busyOutR));

  p_busy_cause_r1: assert property (@(posedge clk) disable iff (!rstN)
    (isMaster && !hit) |=> !busyOutL && !busyOutR);

  p_hold_winner_r4: assert property (@(posedge clk) disable iff (!rstN)
    (isMaster && busyOutR && hit) |=> !busyOutL);

  p_one_write_r6: assert property (@(posedge clk) disable iff (!rstN)
    (isMaster && hit) |-> !(wrGateL && wrGateR));

  p_slave_quiet_r8: assert property (@(posedge clk) disable iff (!rstN)
    !isMaster |-> (!busyOutL && !busyOutR));

  p_slave_inhibit_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!isMaster && (busyInL || busyInR)) |-> !((busyInL && wrGateL) || (busyInR && wrGateR)));

  p_enable_needed_r10: assert property (@(posedge clk) disable iff (!rstN)
    !((wrGateL && !enL) || (wrGateR && !enR)));
endmodule

bind busy_arbiter busy_arbiter_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .isMaster(isMaster),
  .enL(enL), .addrL(addrL), .wrL(wrL),
  .enR(enR), .addrR(addrR), .wrR(wrR),
  .busyInL(busyInL), .busyInR(busyInR),
  .busyOutL(busyOutL), .busyOutR(busyOutR),
  .wrGateL(wrGateL), .wrGateR(wrGateR)
);

// File: tb/tb_busy_arbiter.sv
module tb_busy_arbiter;
  localparam int AW = 12;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic isMaster = 1'b1;
  logic enL = 0, enR = 0, wrL = 0, wrR = 0, busyInL = 0, busyInR = 0;
  logic [AW-1:0] addrL = '0, addrR = '0;
  logic busyOutL, busyOutR, wrGateL, wrGateR;

  int compared = 0;
  int mismatched = 0;

  // reference model state
  int mOwner = 0;          // 0 none, 1 left, 2 right
  bit mBusyL = 0, mBusyR = 0;
  bit mPrevEnL = 0, mPrevEnR = 0;
  int mPrevAddrL = 0, mPrevAddrR = 0;

  always #2.5 clk = ~clk;

  busy_arbiter #(.ADDR_W(AW)) dut (
    .clk(clk), .rstN(rstN), .isMaster(isMaster),
    .enL(enL), .addrL(addrL), .wrL(wrL),
    .enR(enR), .addrR(addrR), .wrR(wrR),
    .busyInL(busyInL), .busyInR(busyInR),
    .busyOutL(busyOutL), .busyOutR(busyOutR),
    .wrGateL(wrGateL), .wrGateR(wrGateR)
  );

  function automatic bit mColl();
    return isMaster && enL && enR && (addrL == addrR);
  endfunction

  function automatic int mWinner();
    bit lh, rh;
    if (mOwner != 0) return mOwner;
    lh = mPrevEnL && (mPrevAddrL == int'(addrL));
    rh = mPrevEnR && (mPrevAddrR == int'(addrR));
    return (lh || !rh) ? 1 : 2;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mOwner = 0; mBusyL = 0; mBusyR = 0;
      mPrevEnL = 0; mPrevEnR = 0; mPrevAddrL = 0; mPrevAddrR = 0;
    end else begin
      int w;
      bit c;
      c = mColl();
      w = mWinner();
      mOwner = c ? w : 0;
      mBusyR = c && (w == 1);
      mBusyL = c && (w == 2);
      mPrevEnL = enL; mPrevEnR = enR;
      mPrevAddrL = int'(addrL); mPrevAddrR = int'(addrR);
    end
  end

  task automatic check1(string tag, string what, bit act, bit exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s actual=%0b expected=%0b at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic compareAll(string tag);
    bit c, eL, eR;
    int w;
    c = mColl();
    w = mWinner();
    if (isMaster) begin
      eL = wrL && enL && !(c && w == 2);
      eR = wrR && enR && !(c && w == 1);
    end else begin
      eL = wrL && enL && !busyInL;
      eR = wrR && enR && !busyInR;
    end
    check1(tag, "busyOutL", busyOutL, mBusyL && isMaster);
    check1(tag, "busyOutR", busyOutR, mBusyR && isMaster);
    check1(tag, "wrGateL", wrGateL, eL);
    check1(tag, "wrGateR", wrGateR, eR);
    if (busyOutL && busyOutR) check1("R2", "both busy", 1'b1, 1'b0);
  endtask

  // drive one cycle of stimulus, then compare 1 ns later
  task automatic step(string tag, bit m, bit eL, int aL, bit wL, bit eR, int aR, bit wR,
                      bit bL = 0, bit bR = 0);
    @(negedge clk);
    isMaster = m; enL = eL; addrL = AW'(aL); wrL = wL;
    enR = eR; addrR = AW'(aR); wrR = wR; busyInL = bL; busyInR = bR;
    #1 compareAll(tag);
  endtask

  // explicit expectation on busy flags, for named scenario points
  task automatic expectBusy(string tag, bit eL, bit eR);
    check1(tag, "busyOutL(direct)", busyOutL, eL);
    check1(tag, "busyOutR(direct)", busyOutR, eR);
  endtask

  initial begin : watchdog
    #400000;
    mismatched++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 check1("R11", "busyOutL", busyOutL, 1'b0);
    check1("R11", "busyOutR", busyOutR, 1'b0);
    @(negedge clk); rstN = 1'b1;

    // R1/R7: distinct addresses, both writes pass, no busy
    step("R1", 1, 1, 5, 1, 1, 9, 1);
    step("R7", 1, 1, 5, 1, 1, 9, 1);
    expectBusy("R1", 0, 0);
    // R3/R6: right arrives on left's address -> left wins, right write masked now
    step("R6", 1, 1, 5, 1, 1, 5, 1);
    check1("R6", "wrGateR first cycle", wrGateR, 1'b0);
    check1("R7", "wrGateL winner", wrGateL, 1'b1);
    expectBusy("R1", 0, 0);
    step("R3", 1, 1, 5, 0, 1, 5, 1);
    expectBusy("R3", 0, 1);
    // R4: hold for several cycles
    for (int i = 0; i < 4; i++) step("R4", 1, 1, 5, 1, 1, 5, 1);
    expectBusy("R4", 0, 1);
    // R5: addresses part, busy still high this cycle, falls next
    step("R5", 1, 1, 5, 1, 1, 6, 1);
    expectBusy("R5", 0, 1);
    step("R5", 1, 1, 5, 1, 1, 6, 1);
    expectBusy("R5", 0, 0);
    // R3: tie, both jump to 20 at once -> left wins
    step("R3", 1, 1, 20, 1, 1, 20, 1);
    check1("R3", "tie wrGateR", wrGateR, 1'b0);
    step("R3", 1, 1, 20, 1, 1, 20, 1);
    expectBusy("R3", 0, 1);
    // R3: right sits on 30, left arrives -> right wins
    step("R3", 1, 1, 7, 1, 1, 30, 1);
    step("R3", 1, 1, 30, 1, 1, 30, 1);
    check1("R6", "late left masked", wrGateL, 1'b0);
    step("R3", 1, 1, 30, 1, 1, 30, 0);
    expectBusy("R3", 1, 0);
    // R5: release by deselecting right
    step("R5", 1, 1, 30, 1, 0, 30, 1);
    check1("R10", "disabled right write", wrGateR, 1'b0);
    step("R5", 1, 1, 30, 1, 0, 30, 0);
    expectBusy("R5", 0, 0);
    // R10: writes with enables low
    step("R10", 1, 0, 3, 1, 0, 3, 1);
    check1("R10", "wrGateL off", wrGateL, 1'b0);
    // R9: busy inputs ignored in master mode
    step("R9", 1, 1, 3, 1, 1, 4, 1, 1, 1);
    check1("R9", "wrGateL", wrGateL, 1'b1);
    check1("R9", "wrGateR", wrGateR, 1'b1);
    step("R9", 1, 1, 3, 1, 1, 4, 1, 1, 1);
    expectBusy("R9", 0, 0);
    // R8: slave mode
    step("R8", 0, 1, 8, 1, 1, 8, 1, 0, 0);
    check1("R8", "slave collide write L", wrGateL, 1'b1);
    check1("R8", "slave collide write R", wrGateR, 1'b1);
    step("R8", 0, 1, 8, 1, 1, 8, 1, 1, 0);
    check1("R8", "inhibit L", wrGateL, 1'b0);
    expectBusy("R8", 0, 0);
    step("R8", 0, 1, 8, 1, 1, 8, 1, 0, 1);
    check1("R8", "inhibit R", wrGateR, 1'b0);
    step("R8", 0, 1, 8, 1, 1, 8, 1, 0, 0);
    expectBusy("R8", 0, 0);
    // back to master with a collision already standing: tie -> left
    step("R3", 1, 1, 8, 1, 1, 8, 1);
    step("R3", 1, 1, 8, 1, 1, 8, 1);
    expectBusy("R3", 0, 1);

    // random phase on a small address range
    for (int i = 0; i < 3000; i++) begin
      step("R2", ($urandom_range(0, 15) != 0), $urandom_range(0, 1), $urandom_range(0, 3),
           $urandom_range(0, 1), $urandom_range(0, 1), $urandom_range(0, 3),
           $urandom_range(0, 1), $urandom_range(0, 1), $urandom_range(0, 1));
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule